// File: doc/BRIEF.md
# Double-Buffered PWM Duty Compare

This block is a single-channel pulse-width modulator with a shadowed duty value. A time base counts either as a sawtooth (0 up to the period value, then back to 0) or as a triangle (up to the period value, then down to 0, turning at each end). A combinational comparator drives the PWM output high while the count is below the active duty value.

Software writes a new duty into a buffer register at any time. The comparator never sees that buffer directly. It uses an active register, which takes the buffered value only at update points chosen by the counting mode. As a result, a period never starts with one duty and ends with another.

While the time base is stopped, the active register follows the buffer, so a fresh duty is in place before counting starts. In sawtooth mode this follow can be blocked by the update-inhibit input. An inhibit input that is set while the time base runs freezes the active duty in every mode.

Top module: `pwm_dbuf_duty`

## Requirements
- R1: During and right after reset, `count` is 0, `countDown` is 0 and `cmpOut` is 0. The buffer and the active duty are both 0.
- R2: With `enable` high and `mode` = 2'b00 (sawtooth), `count` rises by one per clock. In the cycle after `count` ≥ `period`, `count` is 0. `countDown` stays 0.
- R3: With `enable` high and `mode` ≠ 2'b00 (triangle), `count` rises by one per clock while `countDown` is 0. When it reaches `period`, the next cycle has `countDown` = 1 and `count` = `period`−1. It then falls by one per clock. When it reaches 0, the next cycle has `countDown` = 0 and `count` = 1. A `period` of 0 holds `count` at 0.
- R4: With `enable` low, `count` and `countDown` hold their values.
- R5: In sawtooth mode while running with `updDisable` low, the active duty takes the buffer value on the clock edge where `count` ≥ `period`, and at no other edge. The new duty therefore governs the output from `count` = 0 onward.
- R6: In triangle mode 2'b01 while running with `updDisable` low, the active duty takes the buffer value on the edge where `count` is 0, and not at the top turn.
- R7: In triangle modes 2'b10 and 2'b11 while running with `updDisable` low, the active duty takes the buffer value both on the edge where `count` is 0 and on the edge where `count` reaches `period` while counting up.
- R8: While `enable` and `updDisable` are both high, the active duty never changes.
- R9: While `enable` is low, the active duty takes the buffer value on every clock, with one exception: in sawtooth mode the copy happens only when `updDisable` is low. In the triangle modes, `updDisable` has no effect while stopped.
- R10: `cmpOut` is 1 exactly when `count` is below the active duty. A duty of 0 gives a constant low output, and a duty above `period` gives a constant high output.
- R11: A pulse on `dutyWrEn` loads `dutyWrData` into the buffer on that clock edge. If a copy to the active register happens on the same edge, the copy takes the buffer's previous content.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Time base runs when high |
| mode | input | 2 | 00 sawtooth, 01 triangle, 10/11 triangle with double update |
| updDisable | input | 1 | Inhibits copies from buffer to active duty |
| period | input | CW | Period (top count) value |
| dutyWrEn | input | 1 | Buffer write strobe |
| dutyWrData | input | CW | Duty value to write into the buffer |
| cmpOut | output | 1 | PWM compare output |
| count | output | CW | Time base count |
| countDown | output | 1 | 1 while the triangle count falls |

## Verification
The bench writes new duties in the middle of a period in every mode and watches when the output width changes. A design that copied at the wrong point would change the pulse mid-period, or one half-period too early or too late. Other stimulus targets specific corner cases, each tied to a likely defect:
- It stops the time base with the inhibit set, once in sawtooth mode and once in triangle mode. A design that mixed up the two stopped-copy rules would show or hide the new duty at the held count.
- It drives duty 0, duty above the period, mode 11 and a period of 1. These catch off-by-one compares, a missed top turn, and a mode decode that drops the fourth code.

// File: rtl/pwm_dbuf_pkg.sv
package pwm_dbuf_pkg;

  typedef enum logic [1:0] {
    MODE_SAW    = 2'b00,
    MODE_TRI    = 2'b01,
    MODE_TRI2   = 2'b10,
    MODE_TRI2B  = 2'b11
  } pwmMode_e;

  typedef struct packed {
    logic loadActive;
    logic atTop;
    logic atBottom;
  } dutyStrobe_t;

endpackage

// File: rtl/pwm_dbuf_ctrl.sv
module pwm_dbuf_ctrl
  import pwm_dbuf_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  pwmMode_e      mode,
  input  logic          updDisable,
  input  logic [CW-1:0] period,
  output logic [CW-1:0] count,
  output logic          countDown,
  output dutyStrobe_t   strobe
);

  localparam logic [CW-1:0] ZERO = '0;
  localparam logic [CW-1:0] ONE  = {{(CW-1){1'b0}}, 1'b1};

  logic wrapHit;
  logic atTop;
  logic atBottom;
  logic runLoad;
  logic isSaw;

  assign isSaw    = (mode == MODE_SAW);
  assign wrapHit  = (count >= period);
  assign atTop    = !countDown && (count >= period);
  assign atBottom = (count == ZERO);

  always_comb begin
    unique case (mode)
      MODE_SAW: runLoad = wrapHit;
      MODE_TRI: runLoad = atBottom;
      default:  runLoad = atBottom || atTop;
    endcase
  end

  always_comb begin
    strobe.atTop    = atTop;
    strobe.atBottom = atBottom;
    if (enable)
      strobe.loadActive = runLoad && !updDisable;
    else
      strobe.loadActive = isSaw ? !updDisable : 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count     <= ZERO;
      countDown <= 1'b0;
    end else if (enable) begin
      if (isSaw) begin
        countDown <= 1'b0;
        count     <= wrapHit ? ZERO : count + ONE;
      end else if (period == ZERO) begin
        countDown <= 1'b0;
        count     <= ZERO;
      end else if (!countDown) begin
        if (count >= period) begin
          countDown <= 1'b1;
          count     <= count - ONE;
        end else begin
          count <= count + ONE;
        end
      end else if (count == ZERO) begin
        countDown <= 1'b0;
        count     <= ONE;
      end else begin
        count <= count - ONE;
      end
    end
  end

  AST_SAW_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (enable && isSaw && count >= period) |=> (count == ZERO)); // R2
  AST_SAW_UP: assert property (@(posedge clk) disable iff (!rstN)
    (enable && isSaw) |=> !countDown); // R2
  AST_TRI_TURN: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !isSaw && !countDown && period != ZERO && count >= period) |=> countDown); // R3
  AST_HOLD_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> ($stable(count) && $stable(countDown))); // R4

endmodule

// File: rtl/pwm_dbuf_dpath.sv
module pwm_dbuf_dpath
  import pwm_dbuf_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  dutyStrobe_t   strobe,
  input  logic          dutyWrEn,
  input  logic [CW-1:0] dutyWrData,
  input  logic [CW-1:0] count,
  output logic [CW-1:0] bufDuty,
  output logic [CW-1:0] activeDuty,
  output logic          cmpOut
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufDuty    <= '0;
      activeDuty <= '0;
    end else begin
      if (dutyWrEn)
        bufDuty <= dutyWrData;
      if (strobe.loadActive)
        activeDuty <= bufDuty;
    end
  end

  assign cmpOut = (count < activeDuty);

  AST_WRITE_LAND: assert property (@(posedge clk) disable iff (!rstN)
    dutyWrEn |=> (bufDuty == $past(dutyWrData))); // R11

endmodule

// File: rtl/pwm_dbuf_duty.sv
module pwm_dbuf_duty
  import pwm_dbuf_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic [1:0]    mode,
  input  logic          updDisable,
  input  logic [CW-1:0] period,
  input  logic          dutyWrEn,
  input  logic [CW-1:0] dutyWrData,
  output logic          cmpOut,
  output logic [CW-1:0] count,
  output logic          countDown
);

  pwmMode_e    modeSel;
  dutyStrobe_t strobe;
  logic [CW-1:0] bufDuty;
  logic [CW-1:0] activeDuty;

  assign modeSel = pwmMode_e'(mode);

  pwm_dbuf_ctrl #(.CW(CW)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .mode       (modeSel),
    .updDisable (updDisable),
    .period     (period),
    .count      (count),
    .countDown  (countDown),
    .strobe     (strobe)
  );

  pwm_dbuf_dpath #(.CW(CW)) uDpath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .dutyWrEn   (dutyWrEn),
    .dutyWrData (dutyWrData),
    .count      (count),
    .bufDuty    (bufDuty),
    .activeDuty (activeDuty),
    .cmpOut     (cmpOut)
  );

  AST_INHIBIT_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (enable && updDisable) |=> $stable(activeDuty)); // R8
  AST_TRI_STOP_COPY: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && mode != 2'b00) |=> (activeDuty == $past(bufDuty))); // R9

endmodule

// File: tb/pwm_dbuf_duty_test.sv
module pwm_dbuf_duty_test;

  localparam int CW = 16;
  localparam int CLK_PERIOD = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          enable = 1'b0;
  logic [1:0]    mode = 2'b00;
  logic          updDisable = 1'b0;
  logic [CW-1:0] period = '0;
  logic          dutyWrEn = 1'b0;
  logic [CW-1:0] dutyWrData = '0;
  logic          cmpOut;
  logic [CW-1:0] count;
  logic          countDown;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic [CW-1:0] cnt;
    logic          dir;
    logic          cmp;
    string         tag;
  } expItem_t;

  expItem_t expQ[$];

  logic [CW-1:0] mCount = '0;
  logic          mDown = 1'b0;
  logic [CW-1:0] mBuf = '0;
  logic [CW-1:0] mAct = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_dbuf_duty #(.CW(CW)) uut (
    .clk(clk), .rstN(rstN), .enable(enable), .mode(mode),
    .updDisable(updDisable), .period(period), .dutyWrEn(dutyWrEn),
    .dutyWrData(dutyWrData), .cmpOut(cmpOut), .count(count),
    .countDown(countDown)
  );

  // monitor: pops expectations after each rising edge
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      expItem_t e;
      e = expQ.pop_front();
      checks++;
      if (count !== e.cnt || countDown !== e.dir || cmpOut !== e.cmp) begin
        errors++;
        $display("FAIL %s: count=%0d dir=%0b cmp=%0b expected count=%0d dir=%0b cmp=%0b",
                 e.tag, count, countDown, cmpOut, e.cnt, e.dir, e.cmp);
      end
    end
  end

  // driver: one clock with the current inputs, expectation from the requirements
  task automatic step(input string tag);
    logic [CW-1:0] nCount;
    logic          nDown;
    logic          load;
    logic          top;
    logic          bottom;
    expItem_t      e;
    nCount = mCount;
    nDown  = mDown;
    load   = 1'b0;
    top    = !mDown && (mCount >= period);
    bottom = (mCount == 0);
    if (enable) begin
      if (mode == 2'b00) begin
        nDown  = 1'b0;
        nCount = (mCount >= period) ? '0 : mCount + 1'b1;
        load   = (mCount >= period) && !updDisable;
      end else begin
        if (period == 0) begin
          nCount = '0; nDown = 1'b0;
        end else if (!mDown) begin
          if (mCount >= period) begin nDown = 1'b1; nCount = mCount - 1'b1; end
          else nCount = mCount + 1'b1;
        end else if (mCount == 0) begin
          nDown = 1'b0; nCount = 1;
        end else nCount = mCount - 1'b1;
        if (mode == 2'b01) load = bottom && !updDisable;
        else load = (bottom || top) && !updDisable;
      end
    end else begin
      load = (mode == 2'b00) ? !updDisable : 1'b1;
    end
    if (load) mAct = mBuf;
    if (dutyWrEn) mBuf = dutyWrData;
    mCount = nCount;
    mDown  = nDown;
    e.cnt = nCount; e.dir = nDown; e.cmp = (nCount < mAct); e.tag = tag;
    expQ.push_back(e);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic writeDuty(input logic [CW-1:0] d, input string tag);
    dutyWrEn = 1'b1; dutyWrData = d;
    step(tag);
    dutyWrEn = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (count !== '0 || countDown !== 1'b0 || cmpOut !== 1'b0) begin
      errors++;
      $display("FAIL R1: count=%0d dir=%0b cmp=%0b expected 0 0 0", count, countDown, cmpOut);
    end
    rstN = 1'b1;
    run(2, "R1");

    // stopped sawtooth, inhibit clear: buffer follows into active (R9)
    period = 5;
    writeDuty(3, "R11");
    run(2, "R9");
    // running sawtooth, change duty mid-period
    enable = 1'b1;
    run(8, "R2");
    writeDuty(1, "R5");
    run(12, "R5");
    // stop at a held count, inhibit set: no follow in sawtooth (R9, R4)
    enable = 1'b0; updDisable = 1'b1;
    writeDuty(5, "R9");
    run(4, "R4");
    // running with inhibit: frozen duty (R8)
    enable = 1'b1;
    run(14, "R8");
    updDisable = 1'b0;
    run(8, "R5");

    // triangle, single update at zero (R6, R3)
    mode = 2'b01; period = 4;
    run(6, "R3");
    writeDuty(2, "R6");
    run(20, "R6");
    // stopped triangle ignores inhibit (R9)
    enable = 1'b0; updDisable = 1'b1;
    writeDuty(4, "R9");
    run(3, "R9");
    updDisable = 1'b0; enable = 1'b1;
    run(6, "R3");

    // double update (R7)
    mode = 2'b10;
    writeDuty(1, "R7");
    run(10, "R7");
    writeDuty(3, "R7");
    run(12, "R7");
    // fourth code behaves as double update
    mode = 2'b11;
    writeDuty(2, "R7");
    run(12, "R7");

    // duty zero and duty beyond period (R10)
    writeDuty(0, "R10");
    run(12, "R10");
    writeDuty(9, "R10");
    run(12, "R10");
    mode = 2'b00;
    run(10, "R10");
    writeDuty(0, "R10");
    run(10, "R10");

    // tiny period in triangle mode
    mode = 2'b01; period = 1;
    writeDuty(1, "R3");
    run(8, "R3");

    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule